// File: doc/BRIEF.md
# Serial Link Packet Decoder

This block sits behind a serial link receiver and turns its byte stream into actions. Traffic on the line is cut into fixed seven-byte packets. Each packet has a two-byte lead-in (00 then 01), a selector byte, three payload bytes and a closing 00. The selector byte sets what happens to the packet:

- 0xAC: the payload is forwarded, byte by byte, to a downstream byte-wide FIFO.
- 0x53: the packet asks for a remote reset, and the block raises a one-cycle request.
- Any other value: the packet is dropped.

Bytes arrive with a valid strobe and may have gaps between them. A lead-in or closing byte that does not match sends the decoder back to hunting for a new packet. Each such mismatch is counted. A payload byte that meets a full FIFO is lost, and the first such loss is latched as a sticky overflow flag.

Top module: `link_frame_decoder`

## Requirements
- R1: After reset, fifo_wr, reset_req and fifo_overflow are 0, frame_err_count is 0, and the decoder waits for the first lead-in byte.
- R2: In a packet whose third byte is 0xAC, each of bytes 4, 5 and 6 gives one write. fifo_wr is high for exactly one cycle, in the cycle after that byte is accepted, and fifo_data carries the byte. The order is the order on the line, most significant payload byte first.
- R3: A packet with selector 0x53 and a correct closing 00 gives a single-cycle reset_req in the cycle after the closing byte is accepted. It produces no FIFO write.
- R4: A packet with any selector other than 0xAC or 0x53 produces no FIFO write and no reset request.
- R5: Each of the following adds one to frame_err_count and returns the decoder to hunting, where the next accepted byte is treated as a first lead-in byte:
  - a first byte other than 0x00;
  - a second byte other than 0x01;
  - a seventh byte other than 0x00.
- R6: A 0x53 packet whose closing byte is not 0x00 gives no reset_req.
- R7: A payload byte of a 0xAC packet accepted while fifo_full is 1 is not written. The first such loss sets fifo_overflow, which stays at 1 until reset.
- R8: Cycles with rx_valid low change nothing and produce no write or reset request; a packet may be spread over such gaps.
- R9: frame_err_count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| fifo_full | input | 1 | Downstream FIFO cannot take a write |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| reset_req | output | 1 | One-cycle remote reset request |
| frame_err_count | output | ERR_W | Saturating count of envelope errors |
| fifo_overflow | output | 1 | Sticky: a payload byte was lost to a full FIFO |

## Verification
The hardest situation to reach is a stream that has lost packet alignment. In that case, bytes meant as payload or selector land in the lead-in positions, and the decoder has to recover through a chain of errors. Constrained random stimulus produces this by corrupting single bytes, truncating packets and inserting stray bytes. A bench model tracks the expected position in the packet for every byte. Directed sequences then cover a bad closing byte on a reset packet, overflow against a full FIFO, and counter saturation after a long run of garbage.

// File: rtl/link_frame_decoder.sv
module link_frame_decoder #(
  parameter int          ERR_W    = 8,
  parameter logic [7:0]  SEL_DATA = 8'hAC,
  parameter logic [7:0]  SEL_RST  = 8'h53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             fifo_full,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  output logic             reset_req,
  output logic [ERR_W-1:0] frame_err_count,
  output logic             fifo_overflow
);

  localparam logic [2:0] LAST_POS = 3'd6;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [2:0] pos;
  logic [7:0] sel;

  wire is_lead0   = (pos == 3'd0);
  wire is_lead1   = (pos == 3'd1);
  wire is_sel     = (pos == 3'd2);
  wire is_payload = (pos >= 3'd3) && (pos <= 3'd5);
  wire is_tail    = (pos == LAST_POS);

  wire bad_env = (is_lead0 && rx_byte != 8'h00) ||
                 (is_lead1 && rx_byte != 8'h01) ||
                 (is_tail  && rx_byte != 8'h00);

  wire fwd      = is_payload && sel == SEL_DATA;
  wire rst_hit  = is_tail && rx_byte == 8'h00 && sel == SEL_RST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos             <= '0;
      sel             <= '0;
      fifo_wr         <= 1'b0;
      fifo_data       <= '0;
      reset_req       <= 1'b0;
      frame_err_count <= '0;
      fifo_overflow   <= 1'b0;
    end else begin
      fifo_wr   <= 1'b0;
      reset_req <= 1'b0;
      if (rx_valid) begin
        if (bad_env) begin
          pos <= '0;
          if (frame_err_count != ERR_MAX)
            frame_err_count <= frame_err_count + 1'b1;
        end else begin
          pos <= is_tail ? 3'd0 : pos + 3'd1;
        end
        if (is_sel)
          sel <= rx_byte;
        if (fwd) begin
          if (fifo_full) begin
            fifo_overflow <= 1'b1;
          end else begin
            fifo_wr   <= 1'b1;
            fifo_data <= rx_byte;
          end
        end
        if (rst_hit)
          reset_req <= 1'b1;
      end
    end
  end

endmodule

module link_frame_decoder_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic             fifo_full,
  input logic             fifo_wr,
  input logic [7:0]       fifo_data,
  input logic             reset_req,
  input logic [ERR_W-1:0] frame_err_count,
  input logic             fifo_overflow
);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  p_reset_after_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(rx_valid && rx_byte == 8'h00));

  p_no_wr_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid && !fifo_full));

  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> fifo_overflow);

  p_err_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (frame_err_count == $past(frame_err_count) ||
         frame_err_count == $past(frame_err_count) + 1'b1));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!fifo_wr && !reset_req));

  p_wr_rst_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr && reset_req));

endmodule

bind link_frame_decoder link_frame_decoder_chk #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/link_frame_decoder_bench.sv
module link_frame_decoder_bench;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic fifo_full = 1'b0;
  logic fifo_wr, reset_req, fifo_overflow;
  logic [7:0] fifo_data;
  logic [ERR_W-1:0] frame_err_count;

  always #10 clk = ~clk;

  link_frame_decoder #(.ERR_W(ERR_W)) u_link_frame_decoder (.*);

  int total = 0, bad = 0;
  int m_pos = 0;
  logic [7:0] m_sel = '0;
  int m_cnt = 0;
  logic m_ovf = 1'b0;

  function automatic int sat_inc(int c);
    return (c == (1 << ERR_W) - 1) ? c : c + 1;
  endfunction

  task automatic check(string tag, logic ewr, logic [7:0] edat, logic erst);
    total++;
    if (fifo_wr !== ewr || (ewr && fifo_data !== edat) || reset_req !== erst ||
        frame_err_count !== m_cnt[ERR_W-1:0] || fifo_overflow !== m_ovf) begin
      bad++;
      $display("FAIL %s: wr=%b data=%h rst=%b cnt=%0d ovf=%b expected wr=%b data=%h rst=%b cnt=%0d ovf=%b",
               tag, fifo_wr, fifo_data, reset_req, frame_err_count, fifo_overflow,
               ewr, edat, erst, m_cnt, m_ovf);
    end
  endtask

  task automatic send(logic [7:0] b, logic full, string force_tag = "");
    logic ewr = 1'b0, erst = 1'b0, err = 1'b0, lost = 1'b0;
    string tag;
    case (m_pos)
      0: err = (b != 8'h00);
      1: err = (b != 8'h01);
      2: m_sel = b;
      3, 4, 5: if (m_sel == 8'hAC) begin
        if (full) begin lost = 1'b1; m_ovf = 1'b1; end else ewr = 1'b1;
      end
      default: begin
        err = (b != 8'h00);
        erst = !err && m_sel == 8'h53;
      end
    endcase
    if (err) begin m_cnt = sat_inc(m_cnt); m_pos = 0; end
    else m_pos = (m_pos == 6) ? 0 : m_pos + 1;
    tag = ewr ? "R2" : erst ? "R3" : err ? "R5" : lost ? "R7" : "R4";
    if (force_tag != "") tag = force_tag;
    rx_valid = 1'b1; rx_byte = b; fifo_full = full;
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = $urandom;
    check(tag, ewr, b, erst);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      fifo_full = $urandom_range(0, 1);
      @(negedge clk);
      check("R8", 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic packet(logic [7:0] s, logic [23:0] p, logic full, int gap);
    logic [7:0] bytes [7];
    bytes = '{8'h00, 8'h01, s, p[23:16], p[15:8], p[7:0], 8'h00};
    for (int i = 0; i < 7; i++) begin
      send(bytes[i], full);
      if (gap > 0) idle($urandom_range(0, gap));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 8'h00, 1'b0);

    packet(8'hAC, 24'h123456, 1'b0, 0);
    packet(8'hAC, 24'hA5005A, 1'b0, 3);
    packet(8'h53, 24'h000000, 1'b0, 0);
    packet(8'h77, 24'hFFFFFF, 1'b0, 2);
    // R6: reset packet with bad closing byte
    send(8'h00, 1'b0); send(8'h01, 1'b0); send(8'h53, 1'b0);
    send(8'h01, 1'b0); send(8'h02, 1'b0); send(8'h03, 1'b0);
    send(8'h44, 1'b0, "R6");
    // R5: bad second lead-in byte, then recovery
    send(8'h00, 1'b0); send(8'h02, 1'b0);
    packet(8'hAC, 24'hC0FFEE, 1'b0, 0);

    // R7: overflow against a full FIFO
    packet(8'hAC, 24'h010203, 1'b1, 0);
    packet(8'hAC, 24'h445566, 1'b0, 0);

    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(0, 9);
      logic [7:0] s;
      case ($urandom_range(0, 3))
        0, 1: s = 8'hAC;
        2: s = 8'h53;
        default: s = $urandom;
      endcase
      if (kind == 0) send($urandom, $urandom_range(0, 3) == 0);
      else if (kind == 1) begin
        send(8'h00, 1'b0); send(8'h01, 1'b0); send(s, 1'b0);
      end else packet(s, $urandom, $urandom_range(0, 3) == 0, $urandom_range(0, 2));
    end

    // R9: saturation of the error count
    for (int i = 0; i < 300; i++) send(8'hFF, 1'b0, "R9");

    // R1: reset returns everything to idle
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0; m_cnt = 0; m_ovf = 1'b0; m_sel = '0;
    @(negedge clk);
    check("R1", 1'b0, 8'h00, 1'b0);
    packet(8'hAC, 24'hBEEF01, 1'b0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule